// File: doc/BRIEF.md
# Interrupt Request Qualifier

This block decides, every clock, whether the processor core should take a hardware interrupt. It combines the control/status word (global enable, exception level, error level and the 8-bit mask field) with the debug-mode flag and the per-thread interrupt-exempt bit, and evaluates the eight pending lines in one of two ways. In direct mode each pending line is gated by its own mask bit. In external-controller mode the eight pending bits are one unsigned priority level that has to exceed the mask field read as a number.

The block also holds the software-writable part of the interrupt cause word: two software interrupt bits, a vector-select bit, a watch-pending bit and a counter-disable bit. A write port, together with an ISA revision selector, updates these bits. The block turns changes of the counter-disable bit into a run/stop level for a cycle counter, and changes of the software interrupt bits into one-cycle event pulses. The two software bits also feed the two low pending lines.

Top module: `irq_gate_ctl`

## Requirements
- R1: Interrupts are enabled only when status_i[0] (global enable) is 1, status_i[1] (exception level) is 0, status_i[2] (error level) is 0, dbg_mode_i is 0 and tc_exempt_i is 0. Otherwise irq_req_o is 0.
- R2: When eic_mode_i is 1, the pending level is pending > status_i[15:8], compared as unsigned 8-bit numbers. Equal values do not request.
- R3: When eic_mode_i is 0, the pending condition is (pending & status_i[15:8]) != 0. The pending vector is hw_pend_i OR'ed with the two software bits in positions 1:0.
- R4: A write (cause_we_i = 1) changes only cause bits 8, 9, 22 and 23. Bit 27 (counter disable) is also written when isa_rev_i is 2'b01 or 2'b1x. With isa_rev_i = 2'b00 it is left unchanged. All other bits of cause_o read 0.
- R5: With isa_rev_i[1] = 1 (revision 6), writing 1 to bit 22 (watch pending) leaves it unchanged and writing 0 clears it.
- R6: cnt_run_o is 1 while cause bit 27 is 0. Setting the bit stops the counter and clearing it restarts the counter, with effect in the cycle after the write edge.
- R7: When a write changes cause bit 8 or 9, sw_irq_evt_o[0] or sw_irq_evt_o[1] pulses for exactly one cycle after the write edge. The new level is visible on cause_o[8] or cause_o[9] in that same cycle. An unchanged bit gives no pulse.
- R8: irq_req_o is the AND of enable and pending, sampled on a clock edge and held one cycle. It is evaluated against the cause state present before that edge.
- R9: After reset, cause_o is 0, irq_req_o is 0, sw_irq_evt_o is 0 and cnt_run_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 32 | Status word: bit0 enable, bit1 exception level, bit2 error level, bits 15:8 mask |
| hw_pend_i | input | 8 | Hardware pending lines |
| dbg_mode_i | input | 1 | Debug mode active |
| tc_exempt_i | input | 1 | Current thread is exempt from interrupts |
| eic_mode_i | input | 1 | Strap: pending bits are a level from an external controller |
| cause_we_i | input | 1 | Cause write strobe |
| cause_wdata_i | input | 32 | Cause write data |
| isa_rev_i | input | 2 | 00 pre-rev2, 01 rev2..5, 1x rev6 |
| irq_req_o | output | 1 | Registered interrupt request |
| cause_o | output | 32 | Held cause bits |
| cnt_run_o | output | 1 | Cycle counter run enable |
| sw_irq_evt_o | output | 2 | One-cycle change events of the software interrupt bits |

## Verification
The hardest case to reach is the revision-6 clear-only behaviour of the watch-pending bit. Only a write can set that bit, so the stimulus first sets it with a pre-revision-6 write and then issues revision-6 writes of 1 and of 0 to it. The level-compare boundary in external-controller mode also needs care: the stimulus drives a pending level equal to the mask, then one above it, while the software bits contribute to the level. A long random phase mixes all gating inputs, revisions and writes, and a behavioural model checks it every cycle.

// File: rtl/irq_gate_ctl.sv
module irq_gate_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] status_i,
  input  logic [7:0]  hw_pend_i,
  input  logic        dbg_mode_i,
  input  logic        tc_exempt_i,
  input  logic        eic_mode_i,
  input  logic        cause_we_i,
  input  logic [31:0] cause_wdata_i,
  input  logic [1:0]  isa_rev_i,
  output logic        irq_req_o,
  output logic [31:0] cause_o,
  output logic        cnt_run_o,
  output logic [1:0]  sw_irq_evt_o
);
  localparam int ST_EN  = 0;
  localparam int ST_EXC = 1;
  localparam int ST_ERR = 2;
  localparam int C_SW   = 8;
  localparam int C_WTCH = 22;
  localparam int C_VSEL = 23;
  localparam int C_CDIS = 27;

  logic [1:0] sw_q, sw_n, evt_q;
  logic       vsel_q, wtch_q, cdis_q, irq_q;
  logic       vsel_n, wtch_n, cdis_n;

  wire [7:0] pend   = hw_pend_i | {6'b0, sw_q};
  wire [7:0] msk    = status_i[15:8];
  wire       en     = status_i[ST_EN] & ~status_i[ST_EXC] & ~status_i[ST_ERR]
                      & ~dbg_mode_i & ~tc_exempt_i;
  wire       hit    = eic_mode_i ? (pend > msk) : |(pend & msk);
  wire       rev2up = |isa_rev_i;
  wire       rev6   = isa_rev_i[1];

  always_comb begin
    sw_n   = sw_q;
    vsel_n = vsel_q;
    wtch_n = wtch_q;
    cdis_n = cdis_q;
    if (cause_we_i) begin
      sw_n   = cause_wdata_i[C_SW+1:C_SW];
      vsel_n = cause_wdata_i[C_VSEL];
      wtch_n = rev6 ? (wtch_q & cause_wdata_i[C_WTCH]) : cause_wdata_i[C_WTCH];
      if (rev2up) cdis_n = cause_wdata_i[C_CDIS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '0;
      evt_q  <= '0;
      vsel_q <= 1'b0;
      wtch_q <= 1'b0;
      cdis_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sw_q   <= sw_n;
      evt_q  <= sw_n ^ sw_q;
      vsel_q <= vsel_n;
      wtch_q <= wtch_n;
      cdis_q <= cdis_n;
      irq_q  <= en & hit;
    end
  end

  assign irq_req_o    = irq_q;
  assign cnt_run_o    = ~cdis_q;
  assign sw_irq_evt_o = evt_q;
  assign cause_o      = {4'b0, cdis_q, 3'b0, vsel_q, wtch_q, 12'b0, sw_q, 8'b0};

  a_r1_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> $past(status_i[ST_EN] && !status_i[ST_EXC] && !status_i[ST_ERR]
                        && !dbg_mode_i && !tc_exempt_i));

  a_r2_level_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && $past(eic_mode_i)) |->
      ($past(hw_pend_i | {6'b0, cause_o[9:8]}) > $past(status_i[15:8])));

  a_r3_mask_and: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && !$past(eic_mode_i)) |->
      (($past(hw_pend_i | {6'b0, cause_o[9:8]}) & $past(status_i[15:8])) != 8'h00));

  a_r4_cdis_locked_old_rev: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_we_i && isa_rev_i == 2'b00) |=> $stable(cause_o[27]));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_we_i |=> $stable(cause_o));

  a_r5_wp_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_we_i && isa_rev_i[1] && !cause_o[22]) |=> !cause_o[22]);

  a_r6_run_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_we_i |=> $stable(cnt_run_o));

  a_r7_evt_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_irq_evt_o != 2'b00) |-> $past(cause_we_i));
endmodule

// File: tb/tb_irq_gate_ctl.sv
module tb_irq_gate_ctl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] status_i = 0;
  logic [7:0]  hw_pend_i = 0;
  logic        dbg_mode_i = 0, tc_exempt_i = 0, eic_mode_i = 0, cause_we_i = 0;
  logic [31:0] cause_wdata_i = 0;
  logic [1:0]  isa_rev_i = 0;
  logic        irq_req_o, cnt_run_o;
  logic [31:0] cause_o;
  logic [1:0]  sw_irq_evt_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_gate_ctl dut (.*);

  // behavioural reference
  int m_sw, m_iv, m_wp, m_dc, m_irq, m_evt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sw = 0; m_iv = 0; m_wp = 0; m_dc = 0; m_irq = 0; m_evt = 0;
    end else begin
      int pend, msk, en, hit, nsw;
      pend = hw_pend_i | m_sw;
      msk  = status_i[15:8];
      en   = (status_i[0] == 1 && status_i[1] == 0 && status_i[2] == 0 &&
              !dbg_mode_i && !tc_exempt_i) ? 1 : 0;
      if (eic_mode_i) hit = (pend > msk) ? 1 : 0;
      else            hit = ((pend & msk) != 0) ? 1 : 0;
      m_irq = en & hit;
      nsw = m_sw;
      if (cause_we_i) begin
        nsw  = cause_wdata_i[9:8];
        m_iv = cause_wdata_i[23];
        if (isa_rev_i >= 2) begin
          if (cause_wdata_i[22] == 0) m_wp = 0;
        end else m_wp = cause_wdata_i[22];
        if (isa_rev_i != 0) m_dc = cause_wdata_i[27];
      end
      m_evt = nsw ^ m_sw;
      m_sw = nsw;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 R2 R3 R8 irq", {31'b0, irq_req_o}, m_irq);
    chk("R4 R5 cause", cause_o, (m_dc << 27) | (m_iv << 23) | (m_wp << 22) | (m_sw << 8));
    chk("R6 run", {31'b0, cnt_run_o}, (m_dc == 0) ? 1 : 0);
    chk("R7 evt", {30'b0, sw_irq_evt_o}, m_evt);
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] d, input logic [1:0] rev);
    cause_wdata_i = d; isa_rev_i = rev; cause_we_i = 1;
    tick();
    cause_we_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset cause", cause_o, 0);
    chk("R9 reset irq", {31'b0, irq_req_o}, 0);
    chk("R9 reset run", {31'b0, cnt_run_o}, 1);
    chk("R9 reset evt", {30'b0, sw_irq_evt_o}, 0);
    rst_n = 1;
    tick();

    // R3 direct mode
    status_i = 32'h0000_1001; hw_pend_i = 8'h10;
    tick(); @(negedge clk);
    chk("R3 masked line hit", {31'b0, irq_req_o}, 1);
    #1 hw_pend_i = 8'h20; tick(); @(negedge clk);
    chk("R3 unmasked line", {31'b0, irq_req_o}, 0);
    // R1 gating
    #1 hw_pend_i = 8'h10; status_i = 32'h0000_1003; tick(); @(negedge clk);
    chk("R1 exl blocks", {31'b0, irq_req_o}, 0);
    #1 status_i = 32'h0000_1005; tick(); @(negedge clk);
    chk("R1 erl blocks", {31'b0, irq_req_o}, 0);
    #1 status_i = 32'h0000_1001; dbg_mode_i = 1; tick(); @(negedge clk);
    chk("R1 debug blocks", {31'b0, irq_req_o}, 0);
    #1 dbg_mode_i = 0; tc_exempt_i = 1; tick(); @(negedge clk);
    chk("R1 exempt blocks", {31'b0, irq_req_o}, 0);
    #1 tc_exempt_i = 0; status_i = 32'h0000_1000; tick(); @(negedge clk);
    chk("R1 ie clear blocks", {31'b0, irq_req_o}, 0);

    // R2 level compare
    #1 eic_mode_i = 1; status_i = 32'h0000_2001; hw_pend_i = 8'h20; tick(); @(negedge clk);
    chk("R2 equal level no req", {31'b0, irq_req_o}, 0);
    #1 hw_pend_i = 8'h21; tick(); @(negedge clk);
    chk("R2 higher level req", {31'b0, irq_req_o}, 1);
    #1 hw_pend_i = 8'h20; wr(32'h0000_0100, 2'b01);
    @(negedge clk);
    chk("R2 R7 sw bit raises level", {31'b0, irq_req_o}, 1);
    #1 wr(32'h0000_0000, 2'b01);
    eic_mode_i = 0; hw_pend_i = 0;

    // R4 write mask and old revision
    wr(32'hFFFF_FFFF, 2'b00);
    chk("R4 pre-rev2 keeps cdis", cause_o, 32'h00C0_0300);
    chk("R7 both sw events", {30'b0, sw_irq_evt_o}, 2'b11);
    wr(32'h0000_0300, 2'b00);
    chk("R7 no event on same value", {30'b0, sw_irq_evt_o}, 2'b00);
    // R6 counter
    wr(32'h0800_0000, 2'b01);
    chk("R6 stop", {31'b0, cnt_run_o}, 0);
    wr(32'h0000_0000, 2'b01);
    chk("R6 restart", {31'b0, cnt_run_o}, 1);
    // R5 rev6 clear-only
    wr(32'h0040_0000, 2'b00);
    wr(32'h0040_0000, 2'b10);
    chk("R5 write1 keeps set", {31'b0, cause_o[22]}, 1);
    wr(32'h0000_0000, 2'b10);
    chk("R5 write0 clears", {31'b0, cause_o[22]}, 0);
    wr(32'h0040_0000, 2'b11);
    chk("R5 write1 cannot set", {31'b0, cause_o[22]}, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      status_i      = $urandom;
      if ($urandom_range(0, 1)) status_i[2:0] = 3'b001;
      hw_pend_i     = $urandom;
      dbg_mode_i    = ($urandom_range(0, 7) == 0);
      tc_exempt_i   = ($urandom_range(0, 7) == 0);
      eic_mode_i    = $urandom_range(0, 1);
      cause_we_i    = ($urandom_range(0, 2) == 0);
      cause_wdata_i = $urandom;
      isa_rev_i     = $urandom;
      tick();
    end
    cause_we_i = 0;
    tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule